// File: doc/BRIEF.md
# Color steering gain selector

This block sits in front of a per-pixel gain stage in an image-sensor front end. On every rising edge of the pixel sample clock it chooses one of a small set of programmed gain words and presents both the chosen word and its index. The selection steps through a repeating color pattern. The pattern is either three colors long or four colors long, as set by a mode input.

The vertical and horizontal sync lines are sampled only on pixel clock edges. A vertical sync rising edge arms a pending restart. The next horizontal sync rising edge uses that pending restart and sends the pattern back to index 0. The pattern therefore restarts once per frame, on the first line of that frame, and not on every line. Before the first restart after reset, the block holds index 0.

The gain words reach the block as one flat input bus. The selected index and gain word leave the block through a register stage, so they always stay aligned with each other.

Top module: `color_gain_steer`

## Requirements
- R1: With `four_color` = 0 active, the selected index repeats 0,1,2,0,1,2 on successive pixel clocks.
- R2: With `four_color` = 1 active, the selected index repeats 0,1,2,3,0,1,2,3 on successive pixel clocks.
- R3: Both sync lines are sampled on rising clock edges. A rising edge is one sample of 0 followed by one sample of 1. A line held high for many clocks gives one edge only.
- R4: An HD rising edge seen while a VD edge is pending restarts the pattern. Index 0 appears on `sel_idx` two clocks after the clock edge at which HD is first sampled high.
- R5: An HD rising edge with no VD edge pending leaves the pattern running without interruption.
- R6: A single VD edge arms exactly one restart. A second HD edge in the same frame does not restart the pattern.
- R7: After reset, and until the first restart, `sel_idx` stays 0 and `sel_gain` shows gain word 0.
- R8: A change on `four_color` takes effect only at the next restart. Until then the pattern keeps its old length.
- R9: `sel_gain` equals gain word `sel_idx`, as it was on `gain_bus` one clock earlier. Gain word k occupies bits [6k+5:6k] of `gain_bus`.
- R10: While `rst_n` is low at a clock edge, `sel_idx` and `sel_gain` become 0 and any pending restart is cleared.
- R11: When VD and HD rise in the same sample, the VD edge arms a restart. The HD edge uses only a restart that was armed earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_in | input | 1 | Vertical sync level |
| hsync_in | input | 1 | Horizontal sync level |
| four_color | input | 1 | Requested pattern length: 0 selects three colors, 1 selects four |
| gain_bus | input | 24 | Four 6-bit gain words, word k at bits [6k+5:6k] |
| sel_idx | output | 2 | Index of the selected gain word |
| sel_gain | output | 6 | Selected gain word |

## Verification
The hardest case to reach from the ports is a change of mode, or a VD/HD edge pair landing in the same sample, while a restart is already pending or has just been used. Hitting it needs the sync lines, the mode input and the pattern phase to line up in one chosen cycle. Directed sequences set up these alignments on purpose: a mode flip in the middle of a line, coincident VD/HD edges with no restart armed, and repeated HD edges within one frame. A long run of seeded random sync toggles, mode flips and gain rewrites then covers the remaining phase combinations against a cycle model kept in the bench.

// File: rtl/color_steer_pkg.sv
// Shared types for the color steering gain selector.
// Assumes that at most four colors are ever steered.
package color_steer_pkg;

    typedef enum logic {
        PAT_TRI  = 1'b0,
        PAT_QUAD = 1'b1
    } pattern_e;

    // Last index visited by a pattern before it wraps.
    function automatic int unsigned last_of(input pattern_e p);
        return (p == PAT_QUAD) ? 3 : 2;
    endfunction

endpackage

// File: rtl/cs_sync_edge.sv
// Samples a group of sync lines on the pixel clock and flags rising edges.
// A rising edge is one sample of 0 followed by one sample of 1. The lines
// are assumed to be synchronous to the clock or already synchronised.
module cs_sync_edge #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    output logic [N_LINES-1:0] rise
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic cur_q;
        logic prev_q;

        // Keeps the latest sample and the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q  <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                cur_q  <= line_in[g];
                prev_q <= cur_q;
            end
        end

        // Flags the edge during the clock after the first high sample.
        always_comb rise[g] = cur_q & ~prev_q;
    end

endmodule

// File: rtl/cs_frame_arm.sv
// Turns frame and line edges into a once-per-frame restart pulse.
// A frame edge arms the pulse. The next line edge fires it and disarms it.
// A frame edge in the same cycle as the firing re-arms the pulse.
module cs_frame_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_rise,
    input  logic line_rise,
    output logic armed,
    output logic restart
);

    // Fires on a line edge only when a frame edge arrived earlier.
    always_comb restart = line_rise & armed;

    // Holds the pending state between a frame edge and its line edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= frame_rise | (armed & ~restart);
        end
    end

endmodule

// File: rtl/cs_color_seq.sv
// Color index counter. It stays idle at 0 until the first restart. After
// that it advances once per clock and wraps at the end of the active
// pattern. The requested pattern is latched at reset and at each restart.
module cs_color_seq
    import color_steer_pkg::*;
#(
    parameter int MAX_COLORS = 4,
    localparam int IDX_W     = $clog2(MAX_COLORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  pattern_e         pat_req,
    output logic [IDX_W-1:0] idx,
    output logic             running,
    output pattern_e         pat_act
);

    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] idx_nxt;

    // Last index of the pattern in force.
    always_comb last_idx = IDX_W'(last_of(pat_act));

    // Next index: 0 on a restart, hold while idle, otherwise step and wrap.
    always_comb begin
        if (restart) begin
            idx_nxt = '0;
        end else if (!running) begin
            idx_nxt = idx;
        end else if (idx >= last_idx) begin
            idx_nxt = '0;
        end else begin
            idx_nxt = idx + 1'b1;
        end
    end

    // Index, run flag and pattern in force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            running <= 1'b0;
            pat_act <= pat_req;
        end else begin
            idx     <= idx_nxt;
            running <= running | restart;
            if (restart) begin
                pat_act <= pat_req;
            end
        end
    end

endmodule

// File: rtl/cs_gain_out.sv
// Output stage. It selects the gain word for the current index and
// registers the index and the word together, so both are valid in the
// same cycle.
module cs_gain_out #(
    parameter int GAIN_W     = 6,
    parameter int MAX_COLORS = 4,
    localparam int IDX_W     = $clog2(MAX_COLORS),
    localparam int BUS_W     = GAIN_W * MAX_COLORS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BUS_W-1:0]  gain_bus,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [GAIN_W-1:0] sel_gain
);

    logic [GAIN_W-1:0] picked;

    // Word selection from the flat bus.
    always_comb begin
        picked = '0;
        for (int k = 0; k < MAX_COLORS; k++) begin
            if (idx == IDX_W'(k)) begin
                picked = gain_bus[k*GAIN_W +: GAIN_W];
            end
        end
    end

    // Registers the index and the word together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx  <= '0;
            sel_gain <= '0;
        end else begin
            sel_idx  <= idx;
            sel_gain <= picked;
        end
    end

endmodule

// File: rtl/color_gain_steer.sv
// Top level of the color steering gain selector. It selects one gain word
// per pixel clock in a 3- or 4-color pattern, restarted once per frame by
// the first HD edge after a VD edge. Assumes sync pulses last several
// pixel clocks and are synchronous to clk.
module color_gain_steer
    import color_steer_pkg::*;
#(
    parameter int GAIN_W     = 6,
    parameter int MAX_COLORS = 4,
    localparam int IDX_W     = $clog2(MAX_COLORS),
    localparam int BUS_W     = GAIN_W * MAX_COLORS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              hsync_in,
    input  logic              four_color,
    input  logic [BUS_W-1:0]  gain_bus,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [GAIN_W-1:0] sel_gain
);

    logic [1:0]       edges;
    logic             vs_rise;
    logic             hs_rise;
    logic             armed;
    logic             restart;
    logic             running;
    pattern_e         pat_act;
    pattern_e         pat_req;
    logic [IDX_W-1:0] seq_idx;

    // Maps the mode pin onto the pattern type.
    always_comb pat_req = pattern_e'(four_color);

    // Splits the edge flags by line.
    always_comb begin
        vs_rise = edges[0];
        hs_rise = edges[1];
    end

    cs_sync_edge #(.N_LINES(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in ({hsync_in, vsync_in}),
        .rise    (edges)
    );

    cs_frame_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_rise (vs_rise),
        .line_rise  (hs_rise),
        .armed      (armed),
        .restart    (restart)
    );

    cs_color_seq #(.MAX_COLORS(MAX_COLORS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pat_req (pat_req),
        .idx     (seq_idx),
        .running (running),
        .pat_act (pat_act)
    );

    cs_gain_out #(.GAIN_W(GAIN_W), .MAX_COLORS(MAX_COLORS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (seq_idx),
        .gain_bus (gain_bus),
        .sel_idx  (sel_idx),
        .sel_gain (sel_gain)
    );

endmodule

// File: rtl/color_gain_steer_chk.sv
// Property checker for color_gain_steer. It is attached by bind and
// observes the internal signals between the submodules.
module color_gain_steer_chk #(
    parameter int GAIN_W     = 6,
    parameter int MAX_COLORS = 4,
    localparam int IDX_W     = $clog2(MAX_COLORS),
    localparam int BUS_W     = GAIN_W * MAX_COLORS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vs_rise,
    input logic              armed,
    input logic              restart,
    input logic              running,
    input logic              quad_act,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [IDX_W-1:0]  sel_idx,
    input logic [GAIN_W-1:0] sel_gain,
    input logic [BUS_W-1:0]  gain_bus
);

    // R1: the three-color pattern never reaches index 3.
    a_r1_tri_range: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_act |-> cur_idx <= IDX_W'(2));

    // R1 R2: the index steps by one while running and not at the pattern end.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !restart && cur_idx != (quad_act ? IDX_W'(3) : IDX_W'(2)))
        |=> cur_idx == $past(cur_idx) + 1'b1);

    // R4: a restart sends the index to 0.
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cur_idx == '0);

    // R6: a used restart leaves nothing armed unless VD rose again.
    a_r6_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !vs_rise) |=> !armed);

    // R7: the index holds at 0 while idle.
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> cur_idx == '0);

    // R8: the pattern in force changes only at a restart.
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(quad_act));

    // R9: the output index and word follow the index of the previous clock.
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel_idx == $past(cur_idx)) &&
                 (sel_gain == GAIN_W'($past(gain_bus) >> (GAIN_W * $past(cur_idx)))));

endmodule

bind color_gain_steer color_gain_steer_chk #(.GAIN_W(GAIN_W), .MAX_COLORS(MAX_COLORS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vs_rise  (vs_rise),
    .armed    (armed),
    .restart  (restart),
    .running  (running),
    .quad_act (pat_act == color_steer_pkg::PAT_QUAD),
    .cur_idx  (seq_idx),
    .sel_idx  (sel_idx),
    .sel_gain (sel_gain),
    .gain_bus (gain_bus)
);

// File: tb/color_gain_steer_bench.sv
module color_gain_steer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vd = 1'b0;
    logic        hd = 1'b0;
    logic        four_color = 1'b0;
    logic [23:0] gain_bus = '0;
    logic [1:0]  sel_idx;
    logic [5:0]  sel_gain;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Cycle model state, derived from the requirements.
    logic       m_sv = 0, m_pv = 0, m_sh = 0, m_ph = 0, m_pend = 0, m_run = 0, m_act = 0;
    logic [1:0] m_idx = 0, m_oidx = 0;
    logic [5:0] m_ogain = 0;

    always #10 clk = ~clk;

    color_gain_steer u_color_gain_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_in   (vd),
        .hsync_in   (hd),
        .four_color (four_color),
        .gain_bus   (gain_bus),
        .sel_idx    (sel_idx),
        .sel_gain   (sel_gain)
    );

    function automatic logic [5:0] word_of(input logic [23:0] bus, input logic [1:0] k);
        return bus[k*6 +: 6];
    endfunction

    // Advances the model by one clock edge, using the inputs now driven.
    task automatic model_step();
        logic       rv, rh, rs;
        logic [1:0] nidx;
        if (!rst_n) begin
            m_sv = 0; m_pv = 0; m_sh = 0; m_ph = 0; m_pend = 0; m_run = 0;
            m_idx = 0; m_oidx = 0; m_ogain = 0; m_act = four_color;
        end else begin
            rv = m_sv & ~m_pv;
            rh = m_sh & ~m_ph;
            rs = rh & m_pend;
            if (rs)              nidx = 0;
            else if (!m_run)     nidx = m_idx;
            else if (m_idx >= (m_act ? 2'd3 : 2'd2)) nidx = 0;
            else                 nidx = m_idx + 2'd1;
            m_pend  = rv | (m_pend & ~rs);
            if (rs) m_act = four_color;
            m_run   = m_run | rs;
            m_pv    = m_sv; m_sv = vd;
            m_ph    = m_sh; m_sh = hd;
            m_oidx  = m_idx;
            m_ogain = word_of(gain_bus, m_idx);
            m_idx   = nidx;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: step the model, then compare mid-cycle.
    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(sel_idx), int'(m_oidx), "sel_idx");
        check(tag, int'(sel_gain), int'(m_ogain), "sel_gain");
    endtask

    task automatic cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        gain_bus = {6'd44, 6'd33, 6'd22, 6'd11};
        @(negedge clk);
        rst_n = 0;
        cycles(2, "R10 reset");
        rst_n = 1;
        cycles(4, "R7 idle");

        vd = 1; cycles(6, "R3 vd held");
        vd = 0; cycles(2, "R3");
        hd = 1; cycles(6, "R4 restart");
        hd = 0; cycles(8, "R1 three color");

        hd = 1; cycles(6, "R5 R6 no rearm");
        hd = 0; cycles(6, "R5 R6 running");

        four_color = 1; cycles(8, "R8 mode pending");
        vd = 1; cycles(6, "R8"); vd = 0; cycles(3, "R8");
        hd = 1; cycles(6, "R4 R2"); hd = 0; cycles(10, "R2 four color");

        vd = 1; hd = 1; cycles(6, "R11 same sample");
        vd = 0; hd = 0; cycles(6, "R11 no restart");
        hd = 1; cycles(6, "R11 later restart"); hd = 0; cycles(6, "R11");

        gain_bus = {6'd63, 6'd0, 6'd42, 6'd21}; cycles(6, "R9 new words");

        rst_n = 0; four_color = 0; cycles(2, "R10 mid reset");
        rst_n = 1; cycles(4, "R7 after reset");

        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) vd = ~vd;
            if ($urandom_range(0, 7) == 0)  hd = ~hd;
            if ($urandom_range(0, 63) == 0) four_color = ~four_color;
            if ($urandom_range(0, 31) == 0) gain_bus = 24'($urandom);
            if ($urandom_range(0, 1999) == 0) rst_n = 0; else rst_n = 1;
            cyc("R1 R2 R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule